// File: doc/BRIEF.md
# Time Slot Interchange Switch Core

This core moves 8-bit channels between serial time-division streams. Eight receive lines each carry a frame of 32 channel slots, eight bits per slot, most significant bit first. The core turns each received slot into a byte and writes it into a data memory at the address formed by its stream and channel. On the transmit side, each of the eight output lines also carries 32 slots. For every output slot, a connection memory entry decides what is sent. The entry either names an input stream and channel to copy from the data memory, or supplies a fixed byte that the processor wrote.

Each connection entry is 16 bits. The low byte is either the source address or the fixed byte. The high byte holds the per-slot controls: the source select, the driver enable, and a level for a per-stream control pin. The byte for a slot is looked up during the slot before it and loaded into the output shifter at the last bit of that slot. A master enable input can force every output into high impedance, and a global flag can force every slot into fixed-byte mode with its driver on. The processor bus decode sits outside the core and reaches the two memories through plain ports.

Top module: `tsi_switch`

## Requirements
- R1: While reset is asserted, and after it is released, every tx_oe bit, tx_d bit and ctl_out bit is 0. Both memories read back as zero until they are written.
- R2: Each rx line is shifted in MSB first, one bit per clock. At the clock edge that ends bit 7 of channel c, the byte is stored at data address {stream[2:0], c[4:0]}, and dm_rdata returns it combinationally from dm_raddr.
- R3: When high-byte bit 2 is 0 and pe is 0, the output slot carries the data-memory byte at the address held in the low byte (stream in bits 7:5, channel in bits 4:0).
- R4: tx_d sends the slot byte MSB first, one bit per clock. The lookup takes place at the end of the previous slot. Output slot S therefore carries the newest input byte whose own slot index is at most S-2, counting slots continuously across frames. A byte can never leave in its arrival slot or the slot after it.
- R5: When high-byte bit 2 is 1, the low byte itself is sent in that slot in every frame. A new value written by the processor is used from the next lookup onward.
- R6: High-byte bit 0 set to 1 drives tx_oe high for that slot on that stream, provided ode is high. Bit 0 set to 0 keeps tx_oe low.
- R7: While ode is low, every tx_oe bit is 0, whatever the connection entries hold.
- R8: While pe is 1 at the lookup, the slot is handled as if bits 2 and 0 of its high byte were 1.
- R9: High-byte bit 3 sets ctl_out for that stream for the whole duration of the slot.
- R10: Several output slots may name the same input address, and each of them carries that same byte.
- R11: fp high in a cycle makes the next cycle bit 0 of channel 0. Without fp, the counters wrap from channel 31, bit 7 to channel 0, bit 0.
- R12: A cm_we write at cm_addr = {stream, channel} stores cm_wdata, and cm_rdata returns the entry at cm_addr combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fp | input | 1 | Frame alignment pulse, high in the last bit of a frame |
| rx | input | 8 | Serial receive lines, one per stream |
| ode | input | 1 | Master output enable |
| pe | input | 1 | Global fixed-byte mode flag |
| dm_raddr | input | 8 | Data memory read address {stream, channel} |
| dm_rdata | output | 8 | Data memory read data |
| cm_we | input | 1 | Connection memory write strobe |
| cm_addr | input | 8 | Connection memory address {stream, channel} |
| cm_wdata | input | 16 | Connection entry to write {control, low byte} |
| cm_rdata | output | 16 | Connection entry at cm_addr |
| tx_d | output | 8 | Serial transmit data, one per stream |
| tx_oe | output | 8 | Transmit driver enable, one per stream |
| ctl_out | output | 8 | Per-slot control pin level, one per stream |

## Verification
The assertions assume that fp arrives only in the last bit of a frame or during a start-up window before any byte is expected. They also assume that ode and pe change only between clock edges, and that cm_addr is held for the cycle after a write whenever read-back matters. The stimulus pulses fp once during start-up and then every 256 cycles, in the last bit of each frame. It changes pe only in the middle of a slot and changes ode only at frame boundaries. It writes the connection memory in back-to-back cycles and reads it back only while no write is pending.

// File: rtl/tsi_pkg.sv
package tsi_pkg;
  localparam int BYTE_W   = 8;
  localparam int CTL_OE   = 0;
  localparam int CTL_PROC = 2;
  localparam int CTL_PIN  = 3;

  typedef struct packed {
    logic [BYTE_W-1:0] ctl;
    logic [BYTE_W-1:0] low;
  } cm_entry_t;

  typedef struct packed {
    logic [BYTE_W-1:0] data;
    logic              on;
    logic              pin;
  } slot_out_t;

  // Resolve one connection entry into the byte, enable and pin level of a slot.
  function automatic slot_out_t pick_slot(cm_entry_t e, logic pe, logic [BYTE_W-1:0] stored);
    slot_out_t r;
    logic      fixed;
    fixed  = pe | e.ctl[CTL_PROC];
    r.on   = pe | e.ctl[CTL_OE];
    r.pin  = e.ctl[CTL_PIN];
    r.data = fixed ? e.low : stored;
    return r;
  endfunction
endpackage

// File: rtl/tsi_timing.sv
module tsi_timing #(
  parameter int NCH  = 32,
  parameter int BITS = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    fp,
  output logic [$clog2(BITS)-1:0] bit_idx,
  output logic [$clog2(NCH)-1:0]  ch_idx,
  output logic [$clog2(NCH)-1:0]  nxt_ch,
  output logic                    slot_end
);
  localparam int CW = $clog2(NCH);
  localparam int BW = $clog2(BITS);

  assign slot_end = (bit_idx == BW'(BITS-1));
  assign nxt_ch   = (ch_idx == CW'(NCH-1)) ? '0 : ch_idx + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_idx <= '0;
      ch_idx  <= '0;
    end else if (fp) begin
      bit_idx <= '0;
      ch_idx  <= '0;
    end else if (slot_end) begin
      bit_idx <= '0;
      ch_idx  <= nxt_ch;
    end else begin
      bit_idx <= bit_idx + 1'b1;
    end
  end
endmodule

// File: rtl/tsi_rx.sv
module tsi_rx #(
  parameter int NSTR = 8,
  parameter int BITS = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NSTR-1:0]            rx,
  output logic [NSTR-1:0][BITS-1:0]  rx_byte
);
  logic [NSTR-1:0][BITS-2:0] sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr <= '0;
    end else begin
      for (int s = 0; s < NSTR; s++) sr[s] <= rx_byte[s][BITS-2:0];
    end
  end

  for (genvar s = 0; s < NSTR; s++) begin : g_asm
    assign rx_byte[s] = {sr[s], rx[s]};
  end
endmodule

// File: rtl/tsi_tx.sv
module tsi_tx
  import tsi_pkg::*;
#(
  parameter int NSTR = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  slot_out_t [NSTR-1:0]  fet,
  input  logic                  ode,
  output logic [NSTR-1:0]       tx_d,
  output logic [NSTR-1:0]       tx_oe,
  output logic [NSTR-1:0]       ctl_out
);
  logic [NSTR-1:0][BYTE_W-1:0] shreg;
  logic [NSTR-1:0]             on_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg   <= '0;
      on_q    <= '0;
      ctl_out <= '0;
    end else if (load) begin
      for (int t = 0; t < NSTR; t++) begin
        shreg[t]   <= fet[t].data;
        on_q[t]    <= fet[t].on;
        ctl_out[t] <= fet[t].pin;
      end
    end else begin
      for (int t = 0; t < NSTR; t++) shreg[t] <= {shreg[t][BYTE_W-2:0], 1'b0};
    end
  end

  for (genvar t = 0; t < NSTR; t++) begin : g_out
    assign tx_d[t] = shreg[t][BYTE_W-1];
  end
  assign tx_oe = on_q & {NSTR{ode}};
endmodule

// File: rtl/tsi_switch.sv
module tsi_switch
  import tsi_pkg::*;
#(
  parameter int NSTR = 8,
  parameter int NCH  = 32
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              fp,
  input  logic [NSTR-1:0]                   rx,
  input  logic                              ode,
  input  logic                              pe,
  input  logic [$clog2(NSTR*NCH)-1:0]       dm_raddr,
  output logic [BYTE_W-1:0]                 dm_rdata,
  input  logic                              cm_we,
  input  logic [$clog2(NSTR*NCH)-1:0]       cm_addr,
  input  logic [2*BYTE_W-1:0]               cm_wdata,
  output logic [2*BYTE_W-1:0]               cm_rdata,
  output logic [NSTR-1:0]                   tx_d,
  output logic [NSTR-1:0]                   tx_oe,
  output logic [NSTR-1:0]                   ctl_out
);
  localparam int SW    = $clog2(NSTR);
  localparam int CW    = $clog2(NCH);
  localparam int AW    = SW + CW;
  localparam int DEPTH = NSTR * NCH;
  localparam int BW    = $clog2(BYTE_W);

  // Named internal events used by the bound checker.
  logic [BW-1:0]                 bit_idx;
  logic [CW-1:0]                 ch_idx;
  logic [CW-1:0]                 nxt_ch;
  logic                          slot_end;
  logic [NSTR-1:0][BYTE_W-1:0]   rx_byte;
  slot_out_t [NSTR-1:0]          fet;

  logic [BYTE_W-1:0] dmem [DEPTH];
  cm_entry_t         cmem [DEPTH];

  tsi_timing #(.NCH(NCH), .BITS(BYTE_W)) u_timing (
    .clk(clk), .rst_n(rst_n), .fp(fp),
    .bit_idx(bit_idx), .ch_idx(ch_idx), .nxt_ch(nxt_ch), .slot_end(slot_end)
  );

  tsi_rx #(.NSTR(NSTR), .BITS(BYTE_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .rx(rx), .rx_byte(rx_byte)
  );

  // Data memory: all streams of a finished slot land at the same edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) dmem[i] <= '0;
    end else if (slot_end) begin
      for (int s = 0; s < NSTR; s++) dmem[{SW'(s), ch_idx}] <= rx_byte[s];
    end
  end

  // Connection memory: processor writes only.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cmem[i] <= '0;
    end else if (cm_we) begin
      cmem[cm_addr] <= cm_wdata;
    end
  end

  assign dm_rdata = dmem[dm_raddr];
  assign cm_rdata = cmem[cm_addr];

  // Look up the next slot's byte for every output stream.
  always_comb begin
    for (int t = 0; t < NSTR; t++) begin
      fet[t] = pick_slot(cmem[{SW'(t), nxt_ch}], pe,
                         dmem[cmem[{SW'(t), nxt_ch}].low[AW-1:0]]);
    end
  end

  tsi_tx #(.NSTR(NSTR)) u_tx (
    .clk(clk), .rst_n(rst_n), .load(slot_end), .fet(fet), .ode(ode),
    .tx_d(tx_d), .tx_oe(tx_oe), .ctl_out(ctl_out)
  );
endmodule

// File: rtl/tsi_switch_chk.sv
module tsi_switch_chk #(
  parameter int NSTR = 8,
  parameter int NCH  = 32,
  parameter int BITS = 8
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          fp,
  input logic                          ode,
  input logic                          pe,
  input logic                          slot_end,
  input logic [$clog2(BITS)-1:0]       bit_idx,
  input logic [$clog2(NCH)-1:0]        ch_idx,
  input logic [NSTR-1:0]               tx_oe,
  input logic                          cm_we,
  input logic [$clog2(NSTR*NCH)-1:0]   cm_addr,
  input logic [2*BITS-1:0]             cm_wdata,
  input logic [2*BITS-1:0]             cm_rdata
);
  localparam int CW = $clog2(NCH);

  p_hiz_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !ode |-> (tx_oe == '0));

  p_fp_align_r11: assert property (@(posedge clk) disable iff (!rst_n)
    fp |=> (bit_idx == '0 && ch_idx == '0));

  p_wrap_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_end && ch_idx == CW'(NCH-1) && !fp) |=> (ch_idx == '0 && bit_idx == '0));

  p_force_on_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_end && pe) |=> (!ode || (&tx_oe)));

  p_oe_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!slot_end && ode) |=> (!ode || tx_oe == $past(tx_oe)));

  p_cm_store_r12: assert property (@(posedge clk) disable iff (!rst_n)
    cm_we |=> (cm_addr != $past(cm_addr) || cm_rdata == $past(cm_wdata)));
endmodule

bind tsi_switch tsi_switch_chk #(.NSTR(NSTR), .NCH(NCH), .BITS(tsi_pkg::BYTE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .fp(fp), .ode(ode), .pe(pe),
  .slot_end(slot_end), .bit_idx(bit_idx), .ch_idx(ch_idx), .tx_oe(tx_oe),
  .cm_we(cm_we), .cm_addr(cm_addr), .cm_wdata(cm_wdata), .cm_rdata(cm_rdata)
);

// File: tb/test_tsi_switch.sv
module test_tsi_switch;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        fp = 0;
  logic [7:0]  rx = '0;
  logic        ode = 1;
  logic        pe = 0;
  logic [7:0]  dm_raddr = '0;
  logic [7:0]  dm_rdata;
  logic        cm_we = 0;
  logic [7:0]  cm_addr = '0;
  logic [15:0] cm_wdata = '0;
  logic [15:0] cm_rdata;
  logic [7:0]  tx_d, tx_oe, ctl_out;

  tsi_switch i_tsi_switch (
    .clk(clk), .rst_n(rst_n), .fp(fp), .rx(rx), .ode(ode), .pe(pe),
    .dm_raddr(dm_raddr), .dm_rdata(dm_rdata), .cm_we(cm_we), .cm_addr(cm_addr),
    .cm_wdata(cm_wdata), .cm_rdata(cm_rdata), .tx_d(tx_d), .tx_oe(tx_oe), .ctl_out(ctl_out)
  );

  always #10 clk = ~clk;  // 50 MHz

  int errors = 0;
  int checks = 0;
  int n = 0;
  bit done = 0;
  logic [15:0] cfg [256];
  logic [7:0]  got [8];

  typedef struct {
    int         t;
    int         slot;
    logic [7:0] b;
    logic       oe;
    logic       pin;
    bit         chk_b;
    string      tag;
  } exp_t;
  exp_t q[$];

  always @(posedge clk) if (rst_n) n <= n + 1;

  function automatic logic [7:0] rxb(int g, int s, int c);
    return 8'((g * 37 + s * 29 + c * 5 + 3) & 255);
  endfunction

  // Newest input byte whose slot index is at most S-2 (R4).
  function automatic logic [7:0] src_byte(int slot, int s, int c);
    if (slot - 2 - c < 0) return 8'h00;
    return rxb((slot - 2 - c) / 32, s, c);
  endfunction

  // Entry layout: control byte bit 2 fixed mode, bit 0 enable, bit 3 pin.
  function automatic logic [15:0] cfg_word(int t, int k);
    logic [7:0] hi, lo;
    int s, c;
    hi = '0;
    hi[3] = (k % 3 == 0);
    if ((t + k) % 5 == 0) begin
      hi[2] = 1; hi[0] = 1; lo = 8'hA0 ^ 8'(t * 8 + k);
    end else begin
      s = (k + t % 4) % 8;
      c = (k + 32 - t % 4) % 32;
      hi[0] = ((t + k) % 7 != 3);
      lo = {3'(s), 5'(c)};
    end
    return {hi, lo};
  endfunction

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  // Driver: push the expected content of one output slot for all streams.
  task automatic push_slot(int slot);
    int k;
    k = slot % 32;
    for (int t = 0; t < 8; t++) begin
      exp_t e;
      logic [15:0] w;
      logic fixed, on;
      w = cfg[t * 32 + k];
      fixed = pe | w[10];
      on = pe | w[8];
      e.t = t; e.slot = slot; e.pin = w[11];
      e.oe = on & (slot / 32 != 4);
      e.chk_b = on;
      e.b = fixed ? w[7:0] : src_byte(slot, int'(w[7:5]), int'(w[4:0]));
      if (pe) e.tag = "R8";
      else if (fixed) e.tag = "R5";
      else if (k == 0) e.tag = "R11";
      else if (t >= 4) e.tag = "R10";
      else e.tag = "R3";
      q.push_back(e);
    end
  endtask

  // Monitor, then input drive, each falling edge.
  always @(negedge clk) if (rst_n) begin
    int m, slot, b, f, k;
    m = n - 4;
    if (m >= 0) begin
      slot = m / 8; b = m % 8; f = slot / 32; k = slot % 32;
      if (f >= 2 && f <= 7) begin
        if (b == 0) push_slot(slot);
        for (int t = 0; t < 8; t++) got[t][7 - b] = tx_d[t];
        if (b == 7) begin
          for (int t = 0; t < 8; t++) begin
            exp_t e;
            e = q.pop_front();
            check((f == 4) ? "R7" : "R6", 16'(tx_oe[e.t]), 16'(e.oe), $sformatf("oe s%0d t%0d", e.slot, e.t));
            check("R9", 16'(ctl_out[e.t]), 16'(e.pin), $sformatf("pin s%0d t%0d", e.slot, e.t));
            if (e.chk_b && f != 4)
              check(e.tag, 16'(got[e.t]), 16'(e.b), $sformatf("R4 byte s%0d t%0d", e.slot, e.t));
          end
        end
      end
      ode = (f != 4);
      for (int s = 0; s < 8; s++) rx[s] = rxb(f, s, k)[7 - b];
    end
    fp = (n == 3) || (m >= 0 && m % 256 == 255);  // R11 start-up alignment
  end

  task automatic cm_read(int a);
    cm_addr = 8'(a);
    #1;
    check("R12", cm_rdata, cfg[a], $sformatf("cm read %0d", a));
  endtask

  task automatic dm_read(int s, int c);
    int slot;
    dm_raddr = {3'(s), 5'(c)};
    #1;
    slot = (n - 4) / 8;
    check("R2", 16'(dm_rdata), 16'(rxb((slot - 1 - c) / 32, s, c)), $sformatf("dm s%0d c%0d", s, c));
  endtask

  task automatic wait_m(int target);
    while (n - 4 < target) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", 16'(tx_oe), 16'h0, "tx_oe in reset");
    check("R1", 16'(tx_d), 16'h0, "tx_d in reset");
    check("R1", 16'(ctl_out), 16'h0, "ctl_out in reset");
    #1 rst_n = 1;
    dm_raddr = 8'h55;
    #1;
    check("R1", 16'(dm_rdata), 16'h0, "dm after reset");
    cm_addr = 8'h21;
    #1;
    check("R1", cm_rdata, 16'h0, "cm after reset");
    @(negedge clk);
    for (int a = 0; a < 256; a++) begin
      cfg[a] = cfg_word(a / 32, a % 32);
      cm_we = 1; cm_addr = 8'(a); cm_wdata = cfg[a];
      @(negedge clk);
    end
    cm_we = 0;
    cm_read(5);
    cm_read(200);
    wait_m(1100); pe = 1;
    wait_m(1525); pe = 0;
    wait_m(1600);
    cfg[2 * 32 + 3] = {cfg[2 * 32 + 3][15:8], 8'h3C};  // R5 fixed byte update
    cm_we = 1; cm_addr = 8'(2 * 32 + 3); cm_wdata = cfg[2 * 32 + 3];
    @(negedge clk);
    cm_we = 0;
    cm_read(2 * 32 + 3);
    wait_m(1916);
    dm_read(3, 10);
    dm_read(3, 14);
    dm_read(3, 15);
    dm_read(6, 20);
    wait_m(8 * 256 + 16);
    check("R4", 16'(q.size()), 16'h0, "scoreboard drained");
    done = 1;
    summary();
    $finish;
  end

  initial begin
    #(20 * 6000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      summary();
      $finish;
    end
  end
endmodule